// File: doc/BRIEF.md
# Two-Level Translation Lookaside Buffer with Pairwise-LRU Refill

This block translates 32-bit virtual addresses through a small fully associative instruction-side buffer. On a miss there, it searches a larger unified buffer. Every entry carries its own page size (1 KB, 4 KB, 64 KB or 1 MB), an address-space tag, a shared flag and a valid flag. A lookup ends in one of four ways:

- a hit in the small buffer;
- a refill, where exactly one unified entry matches and is copied into the small buffer in the same clock edge;
- a miss in both buffers;
- a multiple-match error.

The small buffer picks its replacement slot from six pairwise-recency bits. A six-bit replacement counter, with a programmable wrap boundary, names the unified slot that a software load writes. The counter advances once for every cycle in which the unified buffer is searched.

The requester holds a lookup request high for one cycle. All result flags, the slot number and the physical address are combinational from the request and the stored state. After a refill, the same request issued on the next cycle hits the freshly filled slot.

Top module: `itlb_refill_unit`

## Requirements
- R1: An entry takes part in a match only when its valid bit is 1. It matches the address-space tag when tag checking is off, when its shared bit is 1, or when its 8-bit tag equals `cur_asid`.
- R2: Tag checking is off only while `sv_mode` and `priv_mode` are both 1. Every other combination checks the tag.
- R3: The page size depends on the 2-bit size code: 0 gives 1 KB, 1 gives 4 KB, 2 gives 64 KB and 3 gives 1 MB. An entry covers exactly one page, starting at `{vpn,10'b0}` with the bits below the page size cleared.
- R4: On a hit or a refill, `lk_paddr` equals `{3'b0,ppn,10'b0}` with the in-page bits cleared, ORed with the in-page bits of `lk_vaddr`.
- R5: When two or more small-buffer entries match, `lk_multi` is 1. The unified buffer is not searched and the counter does not move.
- R6: On a small-buffer miss with exactly one unified match, `lk_fill` is 1 and `lk_slot` names the victim slot. The entry is copied there at the clock edge, and the same lookup on the next cycle gives `lk_hit` on that slot.
- R7: On a small-buffer miss, two or more unified matches give `lk_multi`, and no unified match gives `lk_miss`.
- R8: The victim is always the least recently used slot, where a hit or a fill makes its slot the most recent. After reset the first four fills go to slots 3, 2, 1, 0 in that order.
- R9: `repl_ctr` is 0 after reset. It advances by one for each lookup that searches the unified buffer, and holds in every other cycle.
- R10: When the counter advances, it goes to 0 instead if `repl_bound` is nonzero and the incremented value exceeds `repl_bound`, or if the incremented value passes the last unified index (63).
- R11: `wr_en` writes the presented entry into the unified slot named by `repl_ctr`. It does not change the counter.
- R12: While `lk_req` is 1, exactly one of `lk_hit`, `lk_fill`, `lk_miss` and `lk_multi` is 1. While it is 0, all four are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sv_mode | input | 1 | Single-virtual-space mode bit |
| priv_mode | input | 1 | Processor is in privileged mode |
| cur_asid | input | 8 | Current address-space tag |
| lk_req | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_hit | output | 1 | Single match in the small buffer |
| lk_fill | output | 1 | Refill from the unified buffer this cycle |
| lk_miss | output | 1 | No match in either buffer |
| lk_multi | output | 1 | Multiple-match error |
| lk_slot | output | 2 | Hit slot, or victim slot on a refill |
| lk_paddr | output | 32 | Translated physical address (hit or refill) |
| wr_en | input | 1 | Load an entry into the unified slot at `repl_ctr` |
| wr_vpn | input | 22 | Virtual page number to load |
| wr_asid | input | 8 | Address-space tag to load |
| wr_ppn | input | 19 | Physical page number to load |
| wr_size | input | 2 | Page size code to load |
| wr_shared | input | 1 | Shared flag to load |
| wr_valid | input | 1 | Valid flag to load |
| repl_bound | input | 6 | Counter wrap boundary (0 means no boundary) |
| repl_ctr | output | 6 | Unified replacement counter |

## Verification
The recency bits and the copied entries are hidden state, so the bench's reference model predicts every `lk_slot` on a refill. A corrupted recency bit shows up at the very next refill as the wrong slot number, or as a duplicate fill. That duplicate later appears as `lk_multi` on a lookup that should hit. A counter that steps or wraps wrongly is visible on `repl_ctr` one cycle after the search. It also shows up later, when a load lands in the wrong unified slot and a lookup misses or hits the wrong page. Page-size and tag errors are caught at the exact boundary addresses, on the same cycle as the request.

// File: rtl/tlbr_pkg.sv
package tlbr_pkg;
   localparam int VA_W     = 32;
   localparam int PG_SHIFT = 10;
   localparam int VPN_W    = VA_W - PG_SHIFT;
   localparam int PPN_W    = 19;
   localparam int ASID_W   = 8;
   localparam int PAD_W    = VA_W - PPN_W - PG_SHIFT;

   typedef struct packed {
      logic              valid;
      logic              shared;
      logic [1:0]        size;
      logic [VPN_W-1:0]  vpn;
      logic [ASID_W-1:0] asid;
      logic [PPN_W-1:0]  ppn;
   } tlb_ent_t;

   // in-page offset bits for a size code
   function automatic logic [VA_W-1:0] offset_mask(input logic [1:0] size);
      case (size)
         2'd0:    return 32'h0000_03FF;
         2'd1:    return 32'h0000_0FFF;
         2'd2:    return 32'h0000_FFFF;
         default: return 32'h000F_FFFF;
      endcase
   endfunction
endpackage

// File: rtl/tlbr_search.sv
module tlbr_search
   import tlbr_pkg::*;
#(
   parameter int DEPTH = 4,
   localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
)(
   input  tlb_ent_t [DEPTH-1:0] ents,
   input  logic [VA_W-1:0]      vaddr,
   input  logic [ASID_W-1:0]    asid,
   input  logic                 asid_chk,
   output logic                 any,
   output logic                 multi,
   output logic [IDX_W-1:0]     idx,
   output logic [VA_W-1:0]      paddr
);
   logic [DEPTH-1:0] m;
   tlb_ent_t         sel;
   logic [VA_W-1:0]  sel_msk;

   for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
      logic [VA_W-1:0] msk;
      logic            tag_ok;
      assign msk    = offset_mask(ents[g].size);
      assign tag_ok = !asid_chk || ents[g].shared || (ents[g].asid == asid);
      assign m[g]   = ents[g].valid && tag_ok &&
                      (((vaddr ^ {ents[g].vpn, {PG_SHIFT{1'b0}}}) & ~msk) == '0);
   end

   always_comb begin
      idx = '0;
      for (int i = DEPTH - 1; i >= 0; i--)
         if (m[i]) idx = IDX_W'(i);
   end

   assign any     = |m;
   assign multi   = $countones(m) > 1;
   assign sel     = ents[idx];
   assign sel_msk = offset_mask(sel.size);
   assign paddr   = ({{PAD_W{1'b0}}, sel.ppn, {PG_SHIFT{1'b0}}} & ~sel_msk) | (vaddr & sel_msk);
endmodule

// File: rtl/tlbr_lru4.sv
module tlbr_lru4 (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       use_en,
   input  logic [1:0] use_slot,
   output logic [1:0] victim,
   output logic [5:0] lru_q
);
   // bit pairs: [5]=0v1 [4]=0v2 [3]=0v3 [2]=1v2 [1]=1v3 [0]=2v3, 1 = later slot newer
   logic [3:0] cond;
   logic [5:0] lru_d;

   assign cond[0] = lru_q[5] && lru_q[4] && lru_q[3];
   assign cond[1] = !lru_q[5] && lru_q[2] && lru_q[1];
   assign cond[2] = !lru_q[4] && !lru_q[2] && lru_q[0];
   assign cond[3] = !lru_q[3] && !lru_q[1] && !lru_q[0];

   always_comb begin
      if (cond[0])      victim = 2'd0;
      else if (cond[1]) victim = 2'd1;
      else if (cond[2]) victim = 2'd2;
      else              victim = 2'd3;
   end

   always_comb begin
      case (use_slot)
         2'd0:    lru_d = lru_q & 6'b000111;
         2'd1:    lru_d = (lru_q & 6'b111001) | 6'b100000;
         2'd2:    lru_d = (lru_q & 6'b111110) | 6'b010100;
         default: lru_d = lru_q | 6'b001011;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)      lru_q <= '0;
      else if (use_en) lru_q <= lru_d;
endmodule

// File: rtl/tlbr_urc.sv
module tlbr_urc #(
   parameter int DEPTH = 64,
   localparam int IDX_W = $clog2(DEPTH)
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic [IDX_W-1:0] bound,
   output logic [IDX_W-1:0] ctr
);
   logic [IDX_W:0] nxt;
   logic           wrap;

   assign nxt  = {1'b0, ctr} + 1'b1;
   assign wrap = ((bound != '0) && (nxt > {1'b0, bound})) || (nxt > (IDX_W + 1)'(DEPTH - 1));

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)    ctr <= '0;
      else if (step) ctr <= wrap ? '0 : nxt[IDX_W-1:0];
endmodule

// File: rtl/itlb_refill_unit.sv
module itlb_refill_unit
   import tlbr_pkg::*;
#(
   parameter int UTLB_DEPTH = 64,
   parameter int ITLB_DEPTH = 4,
   localparam int UIDX_W = $clog2(UTLB_DEPTH),
   localparam int IIDX_W = $clog2(ITLB_DEPTH)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sv_mode,
   input  logic              priv_mode,
   input  logic [ASID_W-1:0] cur_asid,
   input  logic              lk_req,
   input  logic [VA_W-1:0]   lk_vaddr,
   output logic              lk_hit,
   output logic              lk_fill,
   output logic              lk_miss,
   output logic              lk_multi,
   output logic [IIDX_W-1:0] lk_slot,
   output logic [VA_W-1:0]   lk_paddr,
   input  logic              wr_en,
   input  logic [VPN_W-1:0]  wr_vpn,
   input  logic [ASID_W-1:0] wr_asid,
   input  logic [PPN_W-1:0]  wr_ppn,
   input  logic [1:0]        wr_size,
   input  logic              wr_shared,
   input  logic              wr_valid,
   input  logic [UIDX_W-1:0] repl_bound,
   output logic [UIDX_W-1:0] repl_ctr
);
   if (UTLB_DEPTH < 2 || (1 << UIDX_W) != UTLB_DEPTH) begin : g_bad_udepth
      $error("UTLB_DEPTH must be a power of two, at least 2");
   end

   tlb_ent_t [ITLB_DEPTH-1:0] itlb_q;
   tlb_ent_t [UTLB_DEPTH-1:0] utlb_q;
   tlb_ent_t                  wr_ent;

   logic              asid_chk;
   logic              i_any, i_multi, u_any, u_multi;
   logic [IIDX_W-1:0] i_idx, vict;
   logic [UIDX_W-1:0] u_idx;
   logic [VA_W-1:0]   i_pa, u_pa;
   logic              i_hit, u_look;
   logic [5:0]        lru_bits;

   assign asid_chk = !(sv_mode && priv_mode);

   tlbr_search #(.DEPTH(ITLB_DEPTH)) u_isrch (
      .ents(itlb_q), .vaddr(lk_vaddr), .asid(cur_asid), .asid_chk(asid_chk),
      .any(i_any), .multi(i_multi), .idx(i_idx), .paddr(i_pa));

   tlbr_search #(.DEPTH(UTLB_DEPTH)) u_usrch (
      .ents(utlb_q), .vaddr(lk_vaddr), .asid(cur_asid), .asid_chk(asid_chk),
      .any(u_any), .multi(u_multi), .idx(u_idx), .paddr(u_pa));

   assign i_hit    = lk_req && i_any && !i_multi;
   assign u_look   = lk_req && !i_any;
   assign lk_hit   = i_hit;
   assign lk_fill  = u_look && u_any && !u_multi;
   assign lk_miss  = u_look && !u_any;
   assign lk_multi = lk_req && (i_multi || (!i_any && u_multi));
   assign lk_slot  = i_hit ? i_idx : vict;
   assign lk_paddr = i_hit ? i_pa : u_pa;

   if (ITLB_DEPTH == 4) begin : g_lru4
      tlbr_lru4 u_lru (
         .clk(clk), .rst_n(rst_n), .use_en(i_hit || lk_fill),
         .use_slot(lk_slot), .victim(vict), .lru_q(lru_bits));
   end else begin : g_bad_idepth
      $error("pairwise recency encoding needs ITLB_DEPTH == 4");
   end

   tlbr_urc #(.DEPTH(UTLB_DEPTH)) u_urc (
      .clk(clk), .rst_n(rst_n), .step(u_look), .bound(repl_bound), .ctr(repl_ctr));

   assign wr_ent = '{valid: wr_valid, shared: wr_shared, size: wr_size,
                     vpn: wr_vpn, asid: wr_asid, ppn: wr_ppn};

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         utlb_q <= '0;
         itlb_q <= '0;
      end else begin
         if (wr_en)   utlb_q[repl_ctr] <= wr_ent;
         if (lk_fill) itlb_q[vict]     <= utlb_q[u_idx];
      end
endmodule

// File: rtl/tlbr_chk.sv
module tlbr_chk #(
   parameter int UIDX_W = 6,
   parameter int IIDX_W = 2
)(
   input logic              clk,
   input logic              rst_n,
   input logic              sv_mode,
   input logic              priv_mode,
   input logic [7:0]        cur_asid,
   input logic              lk_req,
   input logic [31:0]       lk_vaddr,
   input logic              lk_hit,
   input logic              lk_fill,
   input logic              lk_miss,
   input logic              lk_multi,
   input logic [IIDX_W-1:0] lk_slot,
   input logic [UIDX_W-1:0] repl_bound,
   input logic [UIDX_W-1:0] repl_ctr,
   input logic [5:0]        lru_bits,
   input logic [IIDX_W-1:0] vict,
   input logic              u_look
);
   logic [3:0] lru_cand;
   assign lru_cand = {!lru_bits[3] && !lru_bits[1] && !lru_bits[0],
                      !lru_bits[4] && !lru_bits[2] &&  lru_bits[0],
                      !lru_bits[5] &&  lru_bits[2] &&  lru_bits[1],
                       lru_bits[5] &&  lru_bits[4] &&  lru_bits[3]};

   assert_one_result_R12: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({lk_hit, lk_fill, lk_miss, lk_multi}) == (lk_req ? 1 : 0));

   assert_fill_then_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(lk_fill) && lk_req && $stable(lk_vaddr) && $stable(cur_asid) &&
       $stable(sv_mode) && $stable(priv_mode)) |-> (lk_hit && lk_slot == $past(lk_slot)));

   assert_single_lru_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(lru_cand) == 1);

   assert_recent_not_victim_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(lk_hit || lk_fill) |-> vict != $past(lk_slot));

   assert_ctr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !u_look |=> $stable(repl_ctr));

   assert_ctr_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (u_look && repl_bound != '0) |=> repl_ctr <= $past(repl_bound));
endmodule

bind itlb_refill_unit tlbr_chk #(.UIDX_W(UIDX_W), .IIDX_W(IIDX_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .sv_mode(sv_mode), .priv_mode(priv_mode),
   .cur_asid(cur_asid), .lk_req(lk_req), .lk_vaddr(lk_vaddr),
   .lk_hit(lk_hit), .lk_fill(lk_fill), .lk_miss(lk_miss), .lk_multi(lk_multi),
   .lk_slot(lk_slot), .repl_bound(repl_bound), .repl_ctr(repl_ctr),
   .lru_bits(lru_bits), .vict(vict), .u_look(u_look));

// File: tb/sim_itlb_refill_unit.sv
module sim_itlb_refill_unit;
   localparam int UD = 64;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic        sv_mode = 1'b0, priv_mode = 1'b0;
   logic [7:0]  cur_asid = 8'h00;
   logic        lk_req = 1'b0;
   logic [31:0] lk_vaddr = '0;
   logic        lk_hit, lk_fill, lk_miss, lk_multi;
   logic [1:0]  lk_slot;
   logic [31:0] lk_paddr;
   logic        wr_en = 1'b0;
   logic [21:0] wr_vpn = '0;
   logic [7:0]  wr_asid = '0;
   logic [18:0] wr_ppn = '0;
   logic [1:0]  wr_size = '0;
   logic        wr_shared = 1'b0, wr_valid = 1'b0;
   logic [5:0]  repl_bound = '0;
   logic [5:0]  repl_ctr;

   itlb_refill_unit u0 (
      .clk(clk), .rst_n(rst_n), .sv_mode(sv_mode), .priv_mode(priv_mode),
      .cur_asid(cur_asid), .lk_req(lk_req), .lk_vaddr(lk_vaddr),
      .lk_hit(lk_hit), .lk_fill(lk_fill), .lk_miss(lk_miss), .lk_multi(lk_multi),
      .lk_slot(lk_slot), .lk_paddr(lk_paddr), .wr_en(wr_en), .wr_vpn(wr_vpn),
      .wr_asid(wr_asid), .wr_ppn(wr_ppn), .wr_size(wr_size),
      .wr_shared(wr_shared), .wr_valid(wr_valid),
      .repl_bound(repl_bound), .repl_ctr(repl_ctr));

   typedef struct packed {
      logic        v;
      logic        sh;
      logic [1:0]  sz;
      logic [21:0] vpn;
      logic [7:0]  asid;
      logic [18:0] ppn;
   } m_ent_t;

   m_ent_t mu [UD];
   m_ent_t mi [4];
   int     stamp [4];
   int     tick, mctr, nchk, nfail;

   task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   function automatic logic [31:0] m_off(input logic [1:0] sz);
      int sh;
      sh = (sz == 2'd0) ? 10 : (sz == 2'd1) ? 12 : (sz == 2'd2) ? 16 : 20;
      return (32'd1 << sh) - 32'd1;
   endfunction

   function automatic bit m_match(input m_ent_t e, input logic [31:0] va);
      logic [31:0] m;
      m = m_off(e.sz);
      if (!e.v) return 1'b0;
      if (!(sv_mode && priv_mode) && !e.sh && e.asid != cur_asid) return 1'b0;
      return (va & ~m) == ({e.vpn, 10'd0} & ~m);
   endfunction

   function automatic logic [31:0] m_pa(input m_ent_t e, input logic [31:0] va);
      logic [31:0] m;
      m = m_off(e.sz);
      return ({3'd0, e.ppn, 10'd0} & ~m) | (va & m);
   endfunction

   function automatic int m_victim();
      int v;
      v = 0;
      for (int i = 1; i < 4; i++) if (stamp[i] < stamp[v]) v = i;
      return v;
   endfunction

   function automatic int m_step(input int c);
      int n;
      n = c + 1;
      if ((repl_bound != 0 && n > int'(repl_bound)) || n > UD - 1) n = 0;
      return n;
   endfunction

   task automatic do_look(input logic [31:0] va, input string tag);
      int ni, ii, nu, ui, eslot, nctr;
      logic [3:0]  eflags;
      logic [31:0] epa;
      ni = 0; ii = 0; nu = 0; ui = 0; eslot = 0; epa = '0; nctr = mctr;
      for (int i = 0; i < 4; i++)
         if (m_match(mi[i], va)) begin if (ni == 0) ii = i; ni++; end
      if (ni == 1) begin
         eflags = 4'b1000; eslot = ii; epa = m_pa(mi[ii], va);
      end else if (ni > 1) begin
         eflags = 4'b0001;
      end else begin
         nctr = m_step(mctr);
         for (int i = 0; i < UD; i++)
            if (m_match(mu[i], va)) begin if (nu == 0) ui = i; nu++; end
         if (nu == 1) begin
            eflags = 4'b0100; eslot = m_victim(); epa = m_pa(mu[ui], va);
         end else if (nu > 1) eflags = 4'b0001;
         else eflags = 4'b0010;
      end
      @(negedge clk);
      lk_req = 1'b1; lk_vaddr = va;
      #1;
      chk(tag, "result flags {hit,fill,miss,multi}", {28'd0, lk_hit, lk_fill, lk_miss, lk_multi}, {28'd0, eflags});
      if (eflags[3] || eflags[2]) begin
         chk(eflags[2] ? "R8" : tag, "slot", {30'd0, lk_slot}, eslot[31:0]);
         chk("R4", "paddr", lk_paddr, epa);
      end
      @(posedge clk);
      #1;
      lk_req = 1'b0;
      if (eflags[3]) begin tick++; stamp[eslot] = tick; end
      if (eflags[2]) begin tick++; stamp[eslot] = tick; mi[eslot] = mu[ui]; end
      mctr = nctr;
      chk((nctr == 0 && ni == 0) ? "R10" : "R9", "repl_ctr", {26'd0, repl_ctr}, mctr[31:0]);
   endtask

   task automatic do_load(input logic [31:0] va, input logic [1:0] sz, input logic [7:0] a,
                          input logic sh, input logic v, input logic [18:0] ppn);
      m_ent_t e;
      e = '{v: v, sh: sh, sz: sz, vpn: va[31:10], asid: a, ppn: ppn};
      @(negedge clk);
      wr_en = 1'b1; wr_vpn = va[31:10]; wr_asid = a; wr_ppn = ppn;
      wr_size = sz; wr_shared = sh; wr_valid = v;
      @(posedge clk);
      #1;
      wr_en = 1'b0;
      mu[mctr] = e;
      chk("R11", "repl_ctr after load", {26'd0, repl_ctr}, mctr[31:0]);
   endtask

   function automatic logic [31:0] rva();
      logic [31:0] r;
      r = 32'($urandom % 4);
      return 32'h0800_0000 + (r << 20) + (32'($urandom % 16) << 10) + 32'($urandom % 1024);
   endfunction

   initial begin
      #2_000_000;
      nchk++; nfail++;
      $display("FAIL R12 watchdog: actual hang expected finish");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end

   initial begin
      int seed;
      seed = $urandom(32'd2024);
      for (int i = 0; i < UD; i++) mu[i] = '0;
      for (int i = 0; i < 4; i++) begin mi[i] = '0; stamp[i] = 3 - i; end
      tick = 3; mctr = 0; nchk = 0; nfail = 0;
      repeat (3) @(posedge clk);
      #1;
      chk("R9", "repl_ctr at reset", {26'd0, repl_ctr}, 32'd0);
      chk("R12", "idle flags in reset", {28'd0, lk_hit, lk_fill, lk_miss, lk_multi}, 32'd0);
      rst_n = 1'b1;
      @(posedge clk); #1;
      chk("R12", "idle flags", {28'd0, lk_hit, lk_fill, lk_miss, lk_multi}, 32'd0);

      // empty buffers, then a 4 KB page filled and reused
      cur_asid = 8'h11;
      do_look(32'h0040_0ABC, "R7");
      do_load(32'h0040_0000, 2'd1, 8'h11, 1'b0, 1'b1, 19'h12345);
      do_look(32'h0040_0ABC, "R6");
      do_look(32'h0040_0ABC, "R6");
      // tag mismatch and the checking-off mode
      cur_asid = 8'h22;
      do_look(32'h0040_0100, "R1");
      sv_mode = 1'b1; priv_mode = 1'b0;
      do_look(32'h0040_0100, "R2");
      priv_mode = 1'b1;
      do_look(32'h0040_0100, "R2");
      sv_mode = 1'b0; priv_mode = 1'b0; cur_asid = 8'h11;
      // page-size boundaries
      do_load(32'h0100_0000, 2'd3, 8'h11, 1'b0, 1'b1, 19'h0ABCD);
      do_look(32'h010F_FFFF, "R3");
      do_look(32'h0110_0000, "R3");
      do_load(32'h0200_0000, 2'd2, 8'h11, 1'b0, 1'b1, 19'h05555);
      do_look(32'h0200_FFFF, "R3");
      do_look(32'h0201_0000, "R3");
      do_load(32'h0300_0400, 2'd0, 8'h11, 1'b0, 1'b1, 19'h00777);
      do_look(32'h0300_07FF, "R3");
      do_look(32'h0300_0800, "R3");
      do_look(32'h0300_03FF, "R3");
      // shared entry under a foreign tag, and an invalid entry
      do_load(32'h0400_0000, 2'd1, 8'h33, 1'b1, 1'b1, 19'h01111);
      do_look(32'h0400_0010, "R1");
      do_load(32'h0410_0000, 2'd1, 8'h11, 1'b0, 1'b0, 19'h02222);
      do_look(32'h0410_0010, "R1");
      // two overlapping unified entries
      do_load(32'h0600_0000, 2'd1, 8'h11, 1'b0, 1'b1, 19'h03333);
      do_look(32'h06F0_0000, "R7");
      do_load(32'h0600_0000, 2'd2, 8'h11, 1'b0, 1'b1, 19'h04444);
      do_look(32'h0600_0020, "R7");
      // two overlapping small-buffer entries
      do_load(32'h0500_0000, 2'd1, 8'h11, 1'b0, 1'b1, 19'h06666);
      do_look(32'h0500_0000, "R6");
      do_look(32'h05F0_0000, "R7");
      do_load(32'h0500_0000, 2'd3, 8'h11, 1'b0, 1'b1, 19'h07777);
      do_look(32'h0508_0000, "R6");
      do_look(32'h0500_0010, "R5");
      // counter boundary and natural wrap
      repl_bound = 6'd5;
      for (int i = 0; i < 8; i++) do_look(32'h7F00_0000, "R10");
      repl_bound = 6'd0;
      for (int i = 0; i < 66; i++) do_look(32'h7F00_0000, "R10");

      // constrained random traffic
      for (int n = 0; n < 500; n++) begin
         int op;
         op = $urandom % 5;
         if (op == 0) begin
            logic [7:0] a;
            a = ($urandom % 2 == 0) ? 8'h11 : 8'h22;
            do_load(rva(), 2'($urandom % 4), a, ($urandom % 4) == 0, ($urandom % 8) != 0, 19'($urandom));
         end else begin
            if ($urandom % 16 == 0) repl_bound = ($urandom % 2 == 0) ? 6'd0 : 6'($urandom % 64);
            sv_mode = ($urandom % 4) == 0;
            priv_mode = ($urandom % 2) == 0;
            cur_asid = ($urandom % 2 == 0) ? 8'h11 : 8'h22;
            do_look(rva(), "R1");
         end
      end

      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end
endmodule